// File: doc/BRIEF.md
# NAND Transfer Counter and Interrupt Unit

This block paces a data-area transfer between a host DMA engine and a NAND flash device and turns the progress of that transfer into interrupt events. Software loads a byte count, raises a run bit, and the unit grants one byte per accepted strobe from the flash-side datapath. The count steps down to zero. Each byte goes into a small buffer on the DMA side, and the DMA engine drains that buffer one byte per pop.

Two events are tracked: the count reaching zero during a run, and the device ready/busy line rising. Each event has a raw bit, an enable bit, a write-one-to-set port and a write-one-to-clear port. A single interrupt line is raised while any enabled raw bit is set. A result word tells software whether the run finished cleanly: count at zero and buffer drained. It also holds a sticky flag for a run that was stopped with bytes still owed. A write to the control word can pulse a clear to an external ECC accumulator or return the whole unit to its reset state.

Register map (3-bit address): 0 control, 1 byte count, 2 status, 3 raw events, 4 event enable, 5 event set, 6 event clear, 7 result. Event bit 1 is count-done and event bit 0 is device-ready in registers 3 to 6.

Top module: `nand_xfer_irq`

## Requirements
- R1: After reset, every register reads zero except the result register, which reads 1 (done). The outputs `irq`, `xferReq` and `eccClear` are low.
- R2: A write to address 1 loads the byte count. Each byte strobe taken while `xferReq` is high lowers the count by one. A strobe while `xferReq` is low leaves the count unchanged.
- R3: `xferReq` is high exactly when the run bit (control bit 0) is set, the count is nonzero and the DMA-side buffer holds fewer than BUF_DEPTH bytes.
- R4: The strobe that takes the count from 1 to 0 during a run sets raw event bit 1 at the following clock edge.
- R5: A rising edge on `devReady` sets raw event bit 0. A steady high level does not set it again after the bit is cleared. The edge detector starts as if the line were high, so a line already high at reset causes no event.
- R6: Writing address 5 sets each raw bit written as 1. Writing address 6 clears each raw bit written as 1. Bits written as 0 are left alone. A hardware event in the same cycle as a clear leaves the bit set.
- R7: `irq` is high exactly when some raw event bit and the matching enable bit (address 4) are both 1.
- R8: Status bit 0 follows `devReady`, bit 1 follows `ctrlFifoNe`, and bit 2 is high while the DMA-side buffer is non-empty. The buffer gains a byte per accepted strobe and loses one per `dmaPop` when not empty.
- R9: Result bit 0 is high when the count is zero and the buffer is empty. Result bit 1 is set when the run bit is written from 1 to 0 while the count is nonzero. It is cleared when the run bit is written from 0 to 1.
- R10: Writing control bit 2 as 1 clears the run bit, count, buffer occupancy, raw events, enables and the fail flag at the next edge.
- R11: Writing control bit 1 as 1 raises `eccClear` for exactly one cycle after that write.
- R12: The run bit stays set after the count reaches zero, until software writes it 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWr | input | 1 | Register write strobe |
| regAddr | input | 3 | Register address |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data for `regAddr` (combinational) |
| devReady | input | 1 | NAND ready/busy line, high when ready |
| ctrlFifoNe | input | 1 | Controller FIFO not-empty flag, reported in status |
| byteStrobe | input | 1 | Datapath moved one byte (taken only while `xferReq` is high) |
| dmaPop | input | 1 | DMA engine removed one byte from the DMA-side buffer |
| xferReq | output | 1 | Unit will accept a byte strobe this cycle |
| eccClear | output | 1 | One-cycle clear pulse for the ECC accumulator |
| irq | output | 1 | Masked interrupt |

## Verification
The bench fills the DMA-side buffer until the grant falls while bytes are still owed. It then strobes into the closed grant. A unit that ignored the buffer limit, or counted ungranted strobes, would finish early. The last byte must raise the count-done event exactly once. A level-sensitive or missing edge detector on the ready line would either re-fire after a clear or never fire. The bench also puts a clear write and a ready edge in the same cycle, where a design that gave the clear priority would lose the event. It checks that a stopped run with bytes owed leaves a sticky fail. It checks that a soft reset wipes the enables as well as the raw bits. A random phase compares the grant, count and interrupt against a bench model every cycle.

// File: rtl/nand_xfer_irq_pkg.sv
package nand_xfer_irq_pkg;

  localparam int REG_ADDR_W = 3;
  localparam int EVT_N      = 2;

  // event bit positions shared by raw, enable, set and clear registers
  localparam int EVT_RDY = 0;
  localparam int EVT_TC  = 1;

  // control word bit positions
  localparam int CTL_RUN  = 0;
  localparam int CTL_ECC  = 1;
  localparam int CTL_SRST = 2;

  localparam logic [REG_ADDR_W-1:0] ADDR_CTRL   = 3'd0;
  localparam logic [REG_ADDR_W-1:0] ADDR_COUNT  = 3'd1;
  localparam logic [REG_ADDR_W-1:0] ADDR_STATUS = 3'd2;
  localparam logic [REG_ADDR_W-1:0] ADDR_RAW    = 3'd3;
  localparam logic [REG_ADDR_W-1:0] ADDR_EN     = 3'd4;
  localparam logic [REG_ADDR_W-1:0] ADDR_SET    = 3'd5;
  localparam logic [REG_ADDR_W-1:0] ADDR_CLR    = 3'd6;
  localparam logic [REG_ADDR_W-1:0] ADDR_RESULT = 3'd7;

  // strobes from control to datapath
  typedef struct packed {
    logic softRst;
    logic loadCnt;
    logic run;
  } dpCmd_t;

endpackage

// File: rtl/nand_xfer_dp.sv
module nand_xfer_dp
  import nand_xfer_irq_pkg::*;
#(
  parameter int COUNT_W   = 16,
  parameter int BUF_DEPTH = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  dpCmd_t             cmd,
  input  logic [COUNT_W-1:0] loadVal,
  input  logic               devReady,
  input  logic               byteStrobe,
  input  logic               dmaPop,
  output logic [COUNT_W-1:0] count,
  output logic               xferReq,
  output logic               dmaNe,
  output logic               tcEvent,
  output logic               rdyEvent
);

  localparam int OCC_W = $clog2(BUF_DEPTH + 1);
  localparam logic [OCC_W-1:0]   OCC_FULL = OCC_W'(BUF_DEPTH);
  localparam logic [COUNT_W-1:0] CNT_ONE  = COUNT_W'(1);

  logic [OCC_W-1:0] occ;
  logic             readyQ;
  logic             accept;
  logic             drain;

  assign xferReq  = cmd.run && (count != '0) && (occ < OCC_FULL);
  assign accept   = byteStrobe && xferReq;
  assign drain    = dmaPop && (occ != '0);
  assign tcEvent  = accept && (count == CNT_ONE);
  assign rdyEvent = devReady && !readyQ;
  assign dmaNe    = (occ != '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count <= '0;
    end else if (cmd.softRst) begin
      count <= '0;
    end else if (cmd.loadCnt) begin
      count <= loadVal;
    end else if (accept) begin
      count <= count - CNT_ONE;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      occ <= '0;
    end else if (cmd.softRst) begin
      occ <= '0;
    end else begin
      case ({accept, drain})
        2'b10:   occ <= occ + OCC_W'(1);
        2'b01:   occ <= occ - OCC_W'(1);
        default: occ <= occ;
      endcase
    end
  end

  // edge detector starts high so a line already high is not an edge
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) readyQ <= 1'b1;
    else       readyQ <= devReady;
  end

  assert_count_step_R2: assert property (@(posedge clk) disable iff (!rstN)
    (accept && !cmd.loadCnt && !cmd.softRst) |=> (count == $past(count) - CNT_ONE));

  assert_no_req_at_zero_R3: assert property (@(posedge clk) disable iff (!rstN)
    (count == '0) |-> !xferReq);

  assert_occ_bound_R8: assert property (@(posedge clk) disable iff (!rstN)
    occ <= OCC_FULL);

  assert_occ_drain_R8: assert property (@(posedge clk) disable iff (!rstN)
    (drain && !accept && !cmd.softRst) |=> (occ == $past(occ) - OCC_W'(1)));

endmodule

// File: rtl/nand_xfer_ctrl.sv
module nand_xfer_ctrl
  import nand_xfer_irq_pkg::*;
#(
  parameter int COUNT_W = 16,
  parameter int DATA_W  = 32
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  regWr,
  input  logic [REG_ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0]     regWrData,
  output logic [DATA_W-1:0]     regRdData,
  input  logic [COUNT_W-1:0]    count,
  input  logic                  dmaNe,
  input  logic                  tcEvent,
  input  logic                  rdyEvent,
  input  logic                  devReady,
  input  logic                  ctrlFifoNe,
  output dpCmd_t                cmd,
  output logic [COUNT_W-1:0]    loadVal,
  output logic                  eccClear,
  output logic                  irq
);

  logic             runQ;
  logic             failQ;
  logic             eccQ;
  logic [EVT_N-1:0] rawQ;
  logic [EVT_N-1:0] enQ;
  logic [EVT_N-1:0] evt;
  logic             wrCtrl, wrSet, wrClr, wrEn, softRst;
  logic             unusedWrBits;

  assign wrCtrl  = regWr && (regAddr == ADDR_CTRL);
  assign wrSet   = regWr && (regAddr == ADDR_SET);
  assign wrClr   = regWr && (regAddr == ADDR_CLR);
  assign wrEn    = regWr && (regAddr == ADDR_EN);
  assign softRst = wrCtrl && regWrData[CTL_SRST];

  assign cmd.softRst = softRst;
  assign cmd.loadCnt = regWr && (regAddr == ADDR_COUNT);
  assign cmd.run     = runQ;
  assign loadVal     = regWrData[COUNT_W-1:0];
  assign unusedWrBits = ^regWrData;

  always_comb begin
    evt          = '0;
    evt[EVT_TC]  = tcEvent;
    evt[EVT_RDY] = rdyEvent;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runQ  <= 1'b0;
      failQ <= 1'b0;
      eccQ  <= 1'b0;
      enQ   <= '0;
    end else if (softRst) begin
      runQ  <= 1'b0;
      failQ <= 1'b0;
      eccQ  <= 1'b0;
      enQ   <= '0;
    end else begin
      eccQ <= wrCtrl && regWrData[CTL_ECC];
      if (wrCtrl) begin
        runQ <= regWrData[CTL_RUN];
        if (regWrData[CTL_RUN] && !runQ)
          failQ <= 1'b0;
        else if (!regWrData[CTL_RUN] && runQ && (count != '0))
          failQ <= 1'b1;
      end
      if (wrEn) enQ <= regWrData[EVT_N-1:0];
    end
  end

  for (genvar g = 0; g < EVT_N; g++) begin : gEvt
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                          rawQ[g] <= 1'b0;
      else if (softRst)                   rawQ[g] <= 1'b0;
      else if (evt[g] || (wrSet && regWrData[g])) rawQ[g] <= 1'b1;
      else if (wrClr && regWrData[g])     rawQ[g] <= 1'b0;
    end

    assert_set_wins_R6: assert property (@(posedge clk) disable iff (!rstN)
      (wrSet && regWrData[g]) |=> rawQ[g]);
  end

  assign irq      = |(rawQ & enQ);
  assign eccClear = eccQ;

  always_comb begin
    regRdData = '0;
    case (regAddr)
      ADDR_CTRL:   regRdData[CTL_RUN] = runQ;
      ADDR_COUNT:  regRdData[COUNT_W-1:0] = count;
      ADDR_STATUS: regRdData[2:0] = {dmaNe, ctrlFifoNe, devReady};
      ADDR_RAW:    regRdData[EVT_N-1:0] = rawQ;
      ADDR_EN:     regRdData[EVT_N-1:0] = enQ;
      ADDR_RESULT: regRdData[1:0] = {failQ, (count == '0) && !dmaNe};
      default:     regRdData = '0;
    endcase
  end

  assert_tc_sets_raw_R4: assert property (@(posedge clk) disable iff (!rstN)
    (tcEvent && !softRst) |=> rawQ[EVT_TC]);

  assert_rdy_sets_raw_R5: assert property (@(posedge clk) disable iff (!rstN)
    (rdyEvent && !softRst) |=> rawQ[EVT_RDY]);

  assert_clear_works_R6: assert property (@(posedge clk) disable iff (!rstN)
    (wrClr && regWrData[EVT_RDY] && !rdyEvent) |=> !rawQ[EVT_RDY]);

  assert_soft_reset_R10: assert property (@(posedge clk) disable iff (!rstN)
    softRst |=> (rawQ == '0 && enQ == '0 && !runQ && !failQ));

  assert_ecc_pulse_R11: assert property (@(posedge clk) disable iff (!rstN)
    eccQ |=> !eccQ);

  assert_run_holds_R12: assert property (@(posedge clk) disable iff (!rstN)
    (runQ && !wrCtrl) |=> runQ);

endmodule

// File: rtl/nand_xfer_irq.sv
module nand_xfer_irq
  import nand_xfer_irq_pkg::*;
#(
  parameter int COUNT_W   = 16,
  parameter int BUF_DEPTH = 4,
  parameter int DATA_W    = 32
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  regWr,
  input  logic [REG_ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0]     regWrData,
  output logic [DATA_W-1:0]     regRdData,
  input  logic                  devReady,
  input  logic                  ctrlFifoNe,
  input  logic                  byteStrobe,
  input  logic                  dmaPop,
  output logic                  xferReq,
  output logic                  eccClear,
  output logic                  irq
);

  dpCmd_t             cmd;
  logic [COUNT_W-1:0] loadVal;
  logic [COUNT_W-1:0] count;
  logic               dmaNe;
  logic               tcEvent;
  logic               rdyEvent;

  nand_xfer_ctrl #(.COUNT_W(COUNT_W), .DATA_W(DATA_W)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .regWr      (regWr),
    .regAddr    (regAddr),
    .regWrData  (regWrData),
    .regRdData  (regRdData),
    .count      (count),
    .dmaNe      (dmaNe),
    .tcEvent    (tcEvent),
    .rdyEvent   (rdyEvent),
    .devReady   (devReady),
    .ctrlFifoNe (ctrlFifoNe),
    .cmd        (cmd),
    .loadVal    (loadVal),
    .eccClear   (eccClear),
    .irq        (irq)
  );

  nand_xfer_dp #(.COUNT_W(COUNT_W), .BUF_DEPTH(BUF_DEPTH)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .cmd        (cmd),
    .loadVal    (loadVal),
    .devReady   (devReady),
    .byteStrobe (byteStrobe),
    .dmaPop     (dmaPop),
    .count      (count),
    .xferReq    (xferReq),
    .dmaNe      (dmaNe),
    .tcEvent    (tcEvent),
    .rdyEvent   (rdyEvent)
  );

endmodule

// File: tb/nand_xfer_irq_bench.sv
module nand_xfer_irq_bench;

  localparam int DEPTH = 4;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWr = 1'b0;
  logic [2:0]  regAddr = 3'd0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        devReady = 1'b0;
  logic        ctrlFifoNe = 1'b0;
  logic        byteStrobe = 1'b0;
  logic        dmaPop = 1'b0;
  logic        xferReq, eccClear, irq;

  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;

  nand_xfer_irq u_nand_xfer_irq (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .devReady(devReady),
    .ctrlFifoNe(ctrlFifoNe), .byteStrobe(byteStrobe), .dmaPop(dmaPop),
    .xferReq(xferReq), .eccClear(eccClear), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    regWr = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWr = 1'b0; regWrData = '0;
  endtask

  task automatic rdChk(input string req, input logic [2:0] a, input logic [31:0] exp);
    regAddr = a;
    #1;
    check(req, regRdData, exp);
  endtask

  task automatic strobe();
    @(negedge clk);
    byteStrobe = 1'b1;
    @(negedge clk);
    byteStrobe = 1'b0;
  endtask

  task automatic pop();
    @(negedge clk);
    dmaPop = 1'b1;
    @(negedge clk);
    dmaPop = 1'b0;
  endtask

  function automatic logic modelReq(input logic run, input int cnt, input int occ);
    return run && (cnt != 0) && (occ < DEPTH);
  endfunction

  initial begin
    #(20 * 200000);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int cnt, occ, lastDev;
    logic [1:0] raw;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    rdChk("R1 ctrl", 3'd0, 0);
    rdChk("R1 count", 3'd1, 0);
    rdChk("R1 raw", 3'd3, 0);
    rdChk("R1 enable", 3'd4, 0);
    rdChk("R1 result", 3'd7, 1);
    check("R1 irq", irq, 0);
    check("R1 xferReq", xferReq, 0);

    // R2 load, R3 grant needs run
    wr(3'd1, 5);
    wr(3'd4, 2);
    rdChk("R2 load", 3'd1, 5);
    check("R3 no run", xferReq, 0);
    strobe();
    rdChk("R2 strobe without grant", 3'd1, 5);

    wr(3'd0, 1);
    check("R3 grant", xferReq, 1);
    repeat (4) strobe();
    rdChk("R2 four bytes", 3'd1, 1);
    check("R3 buffer full", xferReq, 0);
    rdChk("R8 buffer nonempty", 3'd2, 32'h4);
    strobe();
    rdChk("R2 ignored while full", 3'd1, 1);
    repeat (4) pop();
    rdChk("R8 drained", 3'd2, 0);
    check("R3 grant back", xferReq, 1);
    strobe();
    rdChk("R4 raw tc", 3'd3, 2);
    check("R7 irq tc", irq, 1);
    rdChk("R9 not done while buffered", 3'd7, 0);
    pop();
    rdChk("R9 done", 3'd7, 1);
    rdChk("R12 run held", 3'd0, 1);
    check("R3 zero count", xferReq, 0);

    // R6 set/clear
    wr(3'd6, 2);
    rdChk("R6 clear", 3'd3, 0);
    check("R7 irq off", irq, 0);
    wr(3'd5, 0);
    rdChk("R6 set zero", 3'd3, 0);
    wr(3'd5, 1);
    rdChk("R6 set bit0", 3'd3, 1);
    check("R7 masked", irq, 0);
    wr(3'd4, 3);
    check("R7 enabled", irq, 1);

    // R5 ready edge
    wr(3'd6, 3);
    @(negedge clk);
    devReady = 1'b1;
    @(negedge clk);
    rdChk("R5 rise", 3'd3, 1);
    rdChk("R8 ready status", 3'd2, 1);
    wr(3'd6, 1);
    repeat (3) @(negedge clk);
    rdChk("R5 level no refire", 3'd3, 0);
    devReady = 1'b0;
    @(negedge clk);
    ctrlFifoNe = 1'b1;
    #1;
    rdChk("R8 ctrl fifo", 3'd2, 2);
    ctrlFifoNe = 1'b0;
    // clear and event in one cycle
    @(negedge clk);
    devReady = 1'b1;
    regWr = 1'b1; regAddr = 3'd6; regWrData = 1;
    @(negedge clk);
    regWr = 1'b0; regWrData = 0;
    rdChk("R6 event beats clear", 3'd3, 1);

    // R9 fail flag
    wr(3'd1, 3);
    wr(3'd0, 0);
    rdChk("R9 fail set", 3'd7, 2);
    wr(3'd0, 1);
    rdChk("R9 fail cleared", 3'd7, 0);

    // R11 ecc pulse
    @(negedge clk);
    regWr = 1'b1; regAddr = 3'd0; regWrData = 3;
    @(negedge clk);
    regWr = 1'b0; regWrData = 0;
    check("R11 pulse high", eccClear, 1);
    @(negedge clk);
    check("R11 pulse low", eccClear, 0);

    // R10 soft reset
    wr(3'd5, 3);
    check("R10 pre irq", irq, 1);
    wr(3'd0, 5);
    rdChk("R10 ctrl", 3'd0, 0);
    rdChk("R10 count", 3'd1, 0);
    rdChk("R10 raw", 3'd3, 0);
    rdChk("R10 enable", 3'd4, 0);
    rdChk("R10 result", 3'd7, 1);
    check("R10 irq", irq, 0);

    // random phase
    devReady = 1'b0;
    @(negedge clk);
    wr(3'd4, 3);
    wr(3'd1, 60);
    wr(3'd0, 1);
    cnt = 60; occ = 0; raw = 2'b00; lastDev = 0;
    for (int i = 0; i < 400; i++) begin
      logic bs, pp, dr, doClr, acc, tc, rdy;
      regAddr = 3'd1;
      #1;
      check("R3 random grant", xferReq, modelReq(1'b1, cnt, occ));
      check("R2 random count", regRdData, cnt);
      check("R7 random irq", irq, |raw);
      bs = 1'($urandom % 2);
      pp = 1'(($urandom % 3) == 0);
      dr = 1'(($urandom % 8) < 3);
      doClr = ((i % 16) == 15);
      byteStrobe = bs; dmaPop = pp; devReady = dr;
      if (doClr) begin
        regWr = 1'b1; regAddr = 3'd6; regWrData = 3;
      end
      acc = bs && modelReq(1'b1, cnt, occ);
      tc  = acc && (cnt == 1);
      rdy = dr && !lastDev[0];
      if (doClr) raw = 2'b00;
      raw = raw | {tc, rdy};
      if (acc) cnt--;
      if (acc && !(pp && occ != 0)) occ++;
      else if (!acc && pp && occ != 0) occ--;
      lastDev = int'(dr);
      @(negedge clk);
      regWr = 1'b0; regWrData = 0;
      byteStrobe = 1'b0; dmaPop = 1'b0;
      if (i == 200 && cnt == 0) begin
        regWr = 1'b1; regAddr = 3'd1; regWrData = 30;
        @(negedge clk);
        regWr = 1'b0; regWrData = 0;
        cnt = 30;
        raw[0] = raw[0] | (devReady && !lastDev[0]);
        lastDev = int'(devReady);
      end
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule